// File: doc/BRIEF.md
# Staged Crosspoint Switch with Lane Activity Monitoring

This block connects 17 single-bit input lanes to 17 output lanes. Each output lane is driven by a multiplexer that picks exactly one input lane. Any input may feed any number of outputs at the same time. The lane path is purely combinational, so an output follows its chosen input with no clock in the way.

A host changes the routing through a small parallel port with an address, write data, and separate write and read strobes. Each output's choice is written into a staging bank, one output at a time and in any order. The live bank is left alone until the host issues a commit. The commit copies every staged choice into the live bank on the same clock edge, so a new routing map is applied all at once.

Every input lane also has a watchdog. The watchdog flags a lane that has shown no edge for a set number of clock cycles. These flags stay set until the host clears them, and they can be read back over the port. Flags that are enabled by a mask are combined into one interrupt line.

Top module: `xpt_top`

## Requirements
- R1: After reset, both banks route output n to input n, the fault flags are all 0, the interrupt mask is all 0 and `irq` is low.
- R2: Each output lane equals the input lane picked by its live-bank entry in the same cycle, with no register in the lane path.
- R3: A write to address o (0 to 16) with a value v below 17 in `host_wdata[4:0]` stores v as the staged choice for output o. The output lanes do not change until a commit.
- R4: A write to address 17 copies every staged entry into the live bank on that clock edge. The write data is ignored. With no commit the live bank holds its value.
- R5: A staging write whose 5-bit value is 17 to 31 is dropped, and the entry keeps its old value.
- R6: One input may be chosen by several outputs at the same time. Each of those outputs then carries that input.
- R7: A lane that shows no edge for `LOA_LIMIT` cycles, after a two-stage synchronizer, sets its fault flag (bit i for lane i) once for each quiet period. A lane that keeps toggling does not set its flag.
- R8: Fault flags are sticky. Writing address 18 clears each flag whose data bit is 1 and leaves the flags whose data bit is 0.
- R9: Address 19 holds a 17-bit mask. `irq` is a register that goes high one cycle after any flag is set while its mask bit is 1, and goes low one cycle after no such pair is left.
- R10: A read strobe gives its result on `host_rdata` on the next cycle. Addresses 0 to 16 return the staged choice in bits 4:0. Address 18 returns the flags, address 19 returns the mask, and any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the monitors and the host port |
| rst | input | 1 | Synchronous reset, active high |
| lane_in | input | 17 | Input lanes |
| lane_out | output | 17 | Output lanes (combinational) |
| host_addr | input | 5 | Register address |
| host_wdata | input | 17 | Write data |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 17 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Masked loss-of-activity interrupt |

## Verification
The assertions rely on these assumptions about the host port:
- Only one register access is made per cycle.
- The write strobe is never X once reset has been released.
- Lane inputs may change at any time, because they reach the monitors only through synchronizers.

The stimulus respects all three:
- It changes lanes and host signals on the falling clock edge only.
- It raises `host_wr` and `host_rd` for a single cycle and never both together.
- It holds reset across several rising edges, so every checked register starts from its reset value.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

  typedef enum logic [2:0] {
    HOP_NONE,
    HOP_STAGE,
    HOP_COMMIT,
    HOP_CLEAR,
    HOP_MASK
  } host_op_e;

  // Map an address to its register role for a switch with n lanes.
  function automatic host_op_e classify(input int unsigned addr, input int unsigned n);
    if (addr < n)          return HOP_STAGE;
    else if (addr == n)    return HOP_COMMIT;
    else if (addr == n + 1) return HOP_CLEAR;
    else if (addr == n + 2) return HOP_MASK;
    else                   return HOP_NONE;
  endfunction

endpackage

// File: rtl/xpt_cfg_bank.sv
module xpt_cfg_bank #(
  parameter int N     = 17,
  parameter int SEL_W = 5,
  parameter int IDX_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stage_we,
  input  logic [IDX_W-1:0]   stage_idx,
  input  logic [SEL_W-1:0]   stage_val,
  input  logic               commit,
  output logic [N*SEL_W-1:0] pend_flat,
  output logic [N*SEL_W-1:0] act_flat
);

  logic [SEL_W-1:0] pend [N];
  logic [SEL_W-1:0] act  [N];
  logic             val_ok;

  assign val_ok = (int'(stage_val) < N);

  for (genvar o = 0; o < N; o++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        pend[o] <= SEL_W'(o);
        act[o]  <= SEL_W'(o);
      end else begin
        if (stage_we && val_ok && (int'(stage_idx) == o))
          pend[o] <= stage_val;
        if (commit)
          act[o] <= pend[o];
      end
    end
    assign pend_flat[o*SEL_W +: SEL_W] = pend[o];
    assign act_flat[o*SEL_W +: SEL_W]  = act[o];
  end

endmodule

// File: rtl/xpt_lane_mux.sv
module xpt_lane_mux #(
  parameter int N     = 17,
  parameter int SEL_W = 5
) (
  input  logic [N-1:0]       lane_in,
  input  logic [N*SEL_W-1:0] act_flat,
  output logic [N-1:0]       lane_out
);

  localparam int PAD = 1 << SEL_W;

  logic [PAD-1:0] padded;
  assign padded = PAD'(lane_in);

  for (genvar o = 0; o < N; o++) begin : g_out
    assign lane_out[o] = padded[act_flat[o*SEL_W +: SEL_W]];
  end

endmodule

// File: rtl/xpt_activity_mon.sv
module xpt_activity_mon #(
  parameter int N     = 17,
  parameter int LIMIT = 1024
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lane_in,
  input  logic         clr_en,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] status
);

  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LIMIT - 1);

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [1:0]       sync_q;
    logic             prev_q;
    logic [CNT_W-1:0] quiet_cnt;
    logic             edge_seen;
    logic             hit;

    assign edge_seen = sync_q[1] ^ prev_q;
    assign hit       = !edge_seen && (quiet_cnt == CNT_LAST);

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q    <= '0;
        prev_q    <= 1'b0;
        quiet_cnt <= '0;
        status[i] <= 1'b0;
      end else begin
        sync_q <= {sync_q[0], lane_in[i]};
        prev_q <= sync_q[1];
        if (edge_seen)
          quiet_cnt <= '0;
        else if (quiet_cnt != CNT_TOP)
          quiet_cnt <= quiet_cnt + 1'b1;
        status[i] <= hit | (status[i] & ~(clr_en & clr_bits[i]));
      end
    end
  end

endmodule

// File: rtl/xpt_host_port.sv
module xpt_host_port
  import xpt_pkg::*;
#(
  parameter int N      = 17,
  parameter int SEL_W  = 5,
  parameter int ADDR_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [N-1:0]       host_wdata,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [N*SEL_W-1:0] pend_flat,
  input  logic [N-1:0]       status,
  output logic               stage_we,
  output logic               commit,
  output logic               clr_en,
  output logic [N-1:0]       irq_mask,
  output logic [N-1:0]       host_rdata,
  output logic               irq
);

  host_op_e op;
  logic [N-1:0] rd_next;

  assign op       = classify(int'(host_addr), N);
  assign stage_we = host_wr && (op == HOP_STAGE);
  assign commit   = host_wr && (op == HOP_COMMIT);
  assign clr_en   = host_wr && (op == HOP_CLEAR);

  always_comb begin
    rd_next = '0;
    case (op)
      HOP_STAGE: rd_next = N'(pend_flat[host_addr*SEL_W +: SEL_W]);
      HOP_CLEAR: rd_next = status;
      HOP_MASK:  rd_next = irq_mask;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_mask   <= '0;
      host_rdata <= '0;
      irq        <= 1'b0;
    end else begin
      if (host_wr && (op == HOP_MASK))
        irq_mask <= host_wdata;
      if (host_rd)
        host_rdata <= rd_next;
      irq <= |(status & irq_mask);
    end
  end

endmodule

// File: rtl/xpt_top.sv
module xpt_top #(
  parameter int N_LANES   = 17,
  parameter int LOA_LIMIT = 1024
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [N_LANES-1:0]                lane_in,
  output logic [N_LANES-1:0]                lane_out,
  input  logic [$clog2(N_LANES+3)-1:0]      host_addr,
  input  logic [N_LANES-1:0]                host_wdata,
  input  logic                              host_wr,
  input  logic                              host_rd,
  output logic [N_LANES-1:0]                host_rdata,
  output logic                              irq
);

  localparam int SEL_W  = $clog2(N_LANES);
  localparam int ADDR_W = $clog2(N_LANES + 3);

  logic [N_LANES*SEL_W-1:0] pend_flat;
  logic [N_LANES*SEL_W-1:0] act_flat;
  logic [N_LANES-1:0]       loa_status;
  logic [N_LANES-1:0]       irq_mask;
  logic                     stage_we;
  logic                     commit;
  logic                     clr_en;

  xpt_host_port #(.N(N_LANES), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_port (
    .clk        (clk),
    .rst        (rst),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .pend_flat  (pend_flat),
    .status     (loa_status),
    .stage_we   (stage_we),
    .commit     (commit),
    .clr_en     (clr_en),
    .irq_mask   (irq_mask),
    .host_rdata (host_rdata),
    .irq        (irq)
  );

  xpt_cfg_bank #(.N(N_LANES), .SEL_W(SEL_W), .IDX_W(ADDR_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .stage_we  (stage_we),
    .stage_idx (host_addr),
    .stage_val (host_wdata[SEL_W-1:0]),
    .commit    (commit),
    .pend_flat (pend_flat),
    .act_flat  (act_flat)
  );

  xpt_lane_mux #(.N(N_LANES), .SEL_W(SEL_W)) u_mux (
    .lane_in  (lane_in),
    .act_flat (act_flat),
    .lane_out (lane_out)
  );

  xpt_activity_mon #(.N(N_LANES), .LIMIT(LOA_LIMIT)) u_mon (
    .clk      (clk),
    .rst      (rst),
    .lane_in  (lane_in),
    .clr_en   (clr_en),
    .clr_bits (host_wdata),
    .status   (loa_status)
  );

endmodule

// File: rtl/xpt_checker.sv
module xpt_checker #(
  parameter int N      = 17,
  parameter int SEL_W  = 5,
  parameter int ADDR_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               host_wr,
  input logic [ADDR_W-1:0]  host_addr,
  input logic [N*SEL_W-1:0] pend_flat,
  input logic [N*SEL_W-1:0] act_flat,
  input logic [N-1:0]       status,
  input logic [N-1:0]       irq_mask,
  input logic               irq
);

  logic is_commit;
  logic is_clear;
  assign is_commit = host_wr && (int'(host_addr) == N);
  assign is_clear  = host_wr && (int'(host_addr) == N + 1);

  // R4: commit copies the staged bank into the live bank
  p_commit_copy_r4: assert property (@(posedge clk) disable iff (rst)
    is_commit |=> (act_flat == $past(pend_flat)));

  // R4: without commit the live bank holds
  p_live_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !is_commit |=> $stable(act_flat));

  // R8: no flag falls without a clear write
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    !is_clear |=> ((status & $past(status)) == $past(status)));

  // R9: interrupt follows the masked flags one cycle later
  p_irq_follow_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(status & irq_mask))));

  // R5: staged entries always name a real input
  for (genvar o = 0; o < N; o++) begin : g_rng
    p_stage_range_r5: assert property (@(posedge clk) disable iff (rst)
      int'(pend_flat[o*SEL_W +: SEL_W]) < N);
  end

endmodule

bind xpt_top xpt_checker #(.N(N_LANES), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .host_wr   (host_wr),
  .host_addr (host_addr),
  .pend_flat (pend_flat),
  .act_flat  (act_flat),
  .status    (loa_status),
  .irq_mask  (irq_mask),
  .irq       (irq)
);

// File: tb/tb_xpt_top.sv
module tb_xpt_top;

  localparam int N   = 17;
  localparam int LIM = 64;
  localparam int AW  = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  lanes = '0;
  logic [N-1:0]  lane_out;
  logic [AW-1:0] addr = '0;
  logic [N-1:0]  wdata = '0;
  logic          wr = 1'b0;
  logic          rd = 1'b0;
  logic [N-1:0]  rdata;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  int sel_model [N];

  always #5 clk = ~clk;

  xpt_top #(.N_LANES(N), .LOA_LIMIT(LIM)) dut (
    .clk(clk), .rst(rst), .lane_in(lanes), .lane_out(lane_out),
    .host_addr(addr), .host_wdata(wdata), .host_wr(wr), .host_rd(rd),
    .host_rdata(rdata), .irq(irq)
  );

  // stage table: {addr, data, expected read-back}
  localparam logic [14:0] STAGE_TBL [8] = '{
    {5'd0,  5'd3,  5'd3},
    {5'd1,  5'd3,  5'd3},
    {5'd2,  5'd16, 5'd16},
    {5'd16, 5'd0,  5'd0},
    {5'd5,  5'd17, 5'd5},
    {5'd6,  5'd31, 5'd6},
    {5'd7,  5'd12, 5'd12},
    {5'd16, 5'd9,  5'd9}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_write(input int a, input logic [N-1:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic host_read(input int a, output logic [N-1:0] d);
    @(negedge clk);
    addr = AW'(a); rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic toggle_for(input int cyc, input logic [N-1:0] m);
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      lanes = lanes ^ m;
    end
  endtask

  function automatic logic [N-1:0] model_out(input logic [N-1:0] in);
    logic [N-1:0] r;
    for (int o = 0; o < N; o++) r[o] = in[sel_model[o]];
    return r;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [N-1:0] r;
    logic [N-1:0] pats [3];
    pats[0] = 17'h0A5C3; pats[1] = 17'h1F00F; pats[2] = 17'h13579;
    for (int o = 0; o < N; o++) sel_model[o] = o;

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    lanes = 17'h15A3C; #1;
    check(lane_out == lanes, "R1 identity route", 32'(lane_out), 32'(lanes));
    host_read(16, r);
    check(r == 17'd16, "R1 staged entry 16", 32'(r), 32'd16);
    host_read(18, r);
    check(r == '0, "R1 flags clear", 32'(r), 32'd0);
    host_read(19, r);
    check(r == '0, "R1 mask clear", 32'(r), 32'd0);
    check(irq == 1'b0, "R1 irq low", 32'(irq), 32'd0);

    // R3/R5/R10: table of staging writes with read-back
    for (int t = 0; t < 8; t++) begin
      host_write(int'(STAGE_TBL[t][14:10]), N'(STAGE_TBL[t][9:5]));
      if (int'(STAGE_TBL[t][9:5]) < N) sel_model[STAGE_TBL[t][14:10]] = int'(STAGE_TBL[t][9:5]);
      host_read(int'(STAGE_TBL[t][14:10]), r);
      check(r == N'(STAGE_TBL[t][4:0]), "R3 R5 R10 staged read-back", 32'(r), 32'(STAGE_TBL[t][4:0]));
    end

    // R3: outputs unchanged before commit
    @(negedge clk); lanes = 17'h0F0F1; #1;
    check(lane_out == lanes, "R3 no effect before commit", 32'(lane_out), 32'(lanes));

    // R4: commit, data ignored
    host_write(17, 17'h1FFFF);
    for (int p = 0; p < 3; p++) begin
      @(negedge clk); lanes = pats[p]; #1;
      check(lane_out == model_out(lanes), "R2 R4 routed pattern", 32'(lane_out), 32'(model_out(lanes)));
    end

    // R6: fan-out of input 3 to outputs 0 and 1
    @(negedge clk); lanes = 17'h00008; #1;
    check(lane_out[0] && lane_out[1] && !lane_out[2], "R6 fan-out high", 32'(lane_out), 32'h3);
    lanes = 17'h1FFF7; #1;
    check(!lane_out[0] && !lane_out[1], "R6 fan-out low", 32'(lane_out[1:0]), 32'h0);

    // R2: combinational follow within the cycle
    lanes[12] = ~lanes[12]; #1;
    check(lane_out[7] == lanes[12], "R2 same-cycle follow", 32'(lane_out[7]), 32'(lanes[12]));

    // R10: commit and unused addresses read zero
    host_read(17, r);
    check(r == '0, "R10 commit reads zero", 32'(r), 32'd0);
    host_read(25, r);
    check(r == '0, "R10 unused reads zero", 32'(r), 32'd0);

    // R7: all lanes toggle, then lane 5 goes quiet
    toggle_for(10, '1);
    host_write(18, '1);
    toggle_for(32, ~(17'd1 << 5));
    host_read(18, r);
    check(r == '0, "R7 no flag while short quiet", 32'(r), 32'd0);
    toggle_for(60, ~(17'd1 << 5));
    host_read(18, r);
    check(r == (17'd1 << 5), "R7 lane 5 flagged", 32'(r), 32'(17'd1 << 5));
    check(irq == 1'b0, "R9 masked off", 32'(irq), 32'd0);

    // R9: enable mask bit 5
    host_write(19, 17'd1 << 5);
    @(negedge clk);
    check(irq == 1'b1, "R9 irq raised", 32'(irq), 32'd1);
    host_read(19, r);
    check(r == (17'd1 << 5), "R10 mask read-back", 32'(r), 32'(17'd1 << 5));

    // R8: zero write keeps flag, one clears it
    host_write(18, '0);
    host_read(18, r);
    check(r[5] == 1'b1, "R8 zero write keeps flag", 32'(r), 32'(17'd1 << 5));
    host_write(18, 17'd1 << 5);
    @(negedge clk);
    check(irq == 1'b0, "R8 R9 irq drops after clear", 32'(irq), 32'd0);
    toggle_for(20, ~(17'd1 << 5));
    host_read(18, r);
    check(r[5] == 1'b0, "R7 one flag per quiet period", 32'(r), 32'd0);

    finish_run();
  end

endmodule